// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests from a small set of external lines and from software, ranks them, and offers the most urgent one to a processor. Each line has its own state bits:

- an enable bit;
- a pending bit;
- an active bit;
- a 4-bit priority.

Software reaches this state through a flat register port. Writes are synchronous and reads are combinational.

A programmable grouping value splits each priority into two parts. The upper part is the preemption level. The lower part is the sub-priority. The upper part alone decides whether a request may interrupt the handler that is running. The sub-priority, and after it the line number, only decide which of several waiting requests goes first.

The processor side is a valid/ready pair. `irq_valid` with `irq_id` offers a line. `irq_ready` accepts it, which is the acknowledge. Acceptance happens only in a cycle where both are high.

The offer is not held. While the processor waits, the offered line may change or the offer may drop. This happens when a register write or an edge on an input line changes which request is best. `irq_ready` while `irq_valid` is low has no effect.

When a handler finishes, the processor pulses `done_valid` with `done_id`. The controller has no back-pressure on that path. The active bits form the nesting record, so handlers finish in the reverse order of their acceptance.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Line n's priority lives at address 0x10+n. A write stores bits [3:0] and ignores all higher bits. A read returns the stored 4-bit value. 0 is the most urgent of the 16 levels.
- R2: Writing address 0x00 sets every enable bit whose write-data bit is 1, and writing address 0x01 clears every such bit. Data bits at 0 leave their enable unchanged. Reading either address returns the enable vector in bits [N-1:0].
- R3: Addresses 0x02 (set) and 0x03 (clear) do the same for the pending bits. Reading either returns the pending vector. When a clear and a set reach the same bit in one cycle, the set wins.
- R4: A 0-to-1 transition on `irq_in[n]`, seen between two consecutive clock edges, sets pending bit n. A level that stays high sets nothing further.
- R5: Writing value v to address 0x05 sets pending bit v when v < N. Any other value changes nothing. Reading address 0x05 returns 0.
- R6: Address 0x04 returns the active vector. Writes to it have no effect.
- R7: Address 0x06 holds a 3-bit grouping value g (write-data bits [2:0]; reads return g). With s = min(g,4), the preemption level of priority p is p >> s. The low s bits are the sub-priority.
- R8: The candidate lines are those that are both pending and enabled. Among them, the one with the numerically lowest full 4-bit priority is chosen. A tie goes to the lowest line number.
- R9: `irq_valid` is high when a candidate exists and either no line is active or the chosen line's preemption level is strictly lower than `cur_level`. `irq_id` then names the chosen line.
- R10: Acceptance (`irq_valid && irq_ready` at a clock edge) clears that line's pending bit and sets its active bit. A set of the same pending bit in the same cycle keeps it pending. `done_valid` clears active bit `done_id`.
- R11: `cur_idle` is high when no line is active. Otherwise `cur_level` is the lowest preemption level among the active lines. While idle, `cur_level` reads all ones.
- R12: Reset clears all of the following:
  - the enable, pending and active bits;
  - the priority and grouping registers;
  - the input edge history.

  After reset, `irq_valid` is 0 and `cur_idle` is 1. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Request lines, rising edge pends |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_valid | output | 1 | A line is offered for acceptance |
| irq_id | output | IDX_W | Offered line number |
| irq_ready | input | 1 | Processor accepts the offered line |
| done_valid | input | 1 | Handler completion pulse |
| done_id | input | IDX_W | Line whose handler completed |
| cur_idle | output | 1 | No line active |
| cur_level | output | 4 | Running preemption level |

## Verification
The properties assume three things about the processor:

- `done_valid` names only a line whose active bit is set.
- Completions arrive in reverse order of acceptance.
- `irq_ready` is treated as meaningful only in cycles where `irq_valid` is high.

The stimulus keeps to these rules by driving completions only for lines that an earlier acceptance made active, innermost first. Inputs change at the falling edge, and the expected state is evaluated at the following falling edge.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned GRP_W  = 3;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [GRP_W-1:0]  grp_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_ENA_SET  = 5'h00;
  localparam addr_t A_ENA_CLR  = 5'h01;
  localparam addr_t A_PND_SET  = 5'h02;
  localparam addr_t A_PND_CLR  = 5'h03;
  localparam addr_t A_ACTIVE   = 5'h04;
  localparam addr_t A_SWTRIG   = 5'h05;
  localparam addr_t A_GROUP    = 5'h06;
  localparam int unsigned PRIO_BASE = 16;

  // upper part of a priority after dropping the sub-priority bits
  function automatic prio_t preempt_of(prio_t p, grp_t g);
    int s;
    s = (int'(g) > int'(PRIO_W)) ? int'(PRIO_W) : int'(g);
    return prio_t'(p >> s);
  endfunction
endpackage

// File: rtl/pic_src.sv
`timescale 1ns/1ps
module pic_src #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] rise
);
  logic [NUM_LINES-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= irq_in;
  end

  assign rise = irq_in & ~hist_q;
endmodule

// File: rtl/pic_regs.sv
`timescale 1ns/1ps
module pic_regs import pic_pkg::*; #(
  parameter  int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_we,
  input  addr_t                             reg_addr,
  input  logic [DATA_W-1:0]                 reg_wdata,
  output logic [DATA_W-1:0]                 reg_rdata,
  input  logic [NUM_LINES-1:0]              edge_set,
  input  logic                              ack_fire,
  input  logic [IDX_W-1:0]                  ack_id,
  input  logic                              done_fire,
  input  logic [IDX_W-1:0]                  done_id,
  output logic [NUM_LINES-1:0]              ena_q,
  output logic [NUM_LINES-1:0]              pend_q,
  output logic [NUM_LINES-1:0]              act_q,
  output logic [NUM_LINES-1:0][PRIO_W-1:0]  prio_q,
  output grp_t                              grp_q
);
  logic [NUM_LINES-1:0] wbits;
  logic [NUM_LINES-1:0] trig_vec, ack_vec, done_vec, prio_sel;
  logic                 wr_ena_set, wr_ena_clr, wr_pnd_set, wr_pnd_clr, wr_trig, wr_grp;

  assign wbits      = reg_wdata[NUM_LINES-1:0];
  assign wr_ena_set = reg_we && (reg_addr == A_ENA_SET);
  assign wr_ena_clr = reg_we && (reg_addr == A_ENA_CLR);
  assign wr_pnd_set = reg_we && (reg_addr == A_PND_SET);
  assign wr_pnd_clr = reg_we && (reg_addr == A_PND_CLR);
  assign wr_trig    = reg_we && (reg_addr == A_SWTRIG);
  assign wr_grp     = reg_we && (reg_addr == A_GROUP);

  // per-line decode of the number-addressed events
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign trig_vec[i] = wr_trig && (reg_wdata == DATA_W'(i));
    assign ack_vec[i]  = ack_fire && (ack_id == IDX_W'(i));
    assign done_vec[i] = done_fire && (done_id == IDX_W'(i));
    assign prio_sel[i] = reg_we && (reg_addr == ADDR_W'(PRIO_BASE + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prio_q[i] <= '0;
      else if (prio_sel[i]) prio_q[i] <= reg_wdata[PRIO_W-1:0];
    end
  end

  logic [NUM_LINES-1:0] ena_d, pend_d, act_d, pend_clr, pend_set;

  assign pend_clr = (wr_pnd_clr ? wbits : '0) | ack_vec;
  assign pend_set = (wr_pnd_set ? wbits : '0) | trig_vec | edge_set;

  always_comb begin
    ena_d = ena_q;
    if (wr_ena_set) ena_d = ena_d | wbits;
    if (wr_ena_clr) ena_d = ena_d & ~wbits;
    pend_d = (pend_q & ~pend_clr) | pend_set;
    act_d  = (act_q & ~done_vec) | ack_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      pend_q <= '0;
      act_q  <= '0;
      grp_q  <= '0;
    end else begin
      ena_q  <= ena_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      if (wr_grp) grp_q <= reg_wdata[GRP_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ENA_SET, A_ENA_CLR: reg_rdata[NUM_LINES-1:0] = ena_q;
      A_PND_SET, A_PND_CLR: reg_rdata[NUM_LINES-1:0] = pend_q;
      A_ACTIVE:             reg_rdata[NUM_LINES-1:0] = act_q;
      A_GROUP:              reg_rdata[GRP_W-1:0]     = grp_q;
      default: begin
        for (int i = 0; i < NUM_LINES; i++) begin
          if (reg_addr == ADDR_W'(PRIO_BASE + i)) reg_rdata[PRIO_W-1:0] = prio_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/pic_arb.sv
`timescale 1ns/1ps
module pic_arb import pic_pkg::*; #(
  parameter  int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0]             cand,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  output logic                             found,
  output logic [IDX_W-1:0]                 best_id,
  output prio_t                            best_prio
);
  // strict compare in ascending order keeps the lower index on ties
  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!found || (prio[i] < best_prio))) begin
        found     = 1'b1;
        best_id   = IDX_W'(i);
        best_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/pic_run.sv
`timescale 1ns/1ps
module pic_run import pic_pkg::*; #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic [NUM_LINES-1:0]             act,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  input  grp_t                             grp,
  output logic                             idle,
  output prio_t                            level
);
  prio_t pre [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_pre
    assign pre[i] = preempt_of(prio[i], grp);
  end

  always_comb begin
    idle  = 1'b1;
    level = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (act[i]) begin
        idle = 1'b0;
        if (pre[i] < level) level = pre[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl import pic_pkg::*; #(
  parameter  int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_valid,
  output logic [IDX_W-1:0]     irq_id,
  input  logic                 irq_ready,
  input  logic                 done_valid,
  input  logic [IDX_W-1:0]     done_id,
  output logic                 cur_idle,
  output logic [PRIO_W-1:0]    cur_level
);
  logic [NUM_LINES-1:0]             rise;
  logic [NUM_LINES-1:0]             ena_q, pend_q, act_q;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
  grp_t                             grp_q;
  logic                             found;
  logic [IDX_W-1:0]                 best_id;
  prio_t                            best_prio, best_pre;
  logic                             ack_fire;

  pic_src #(.NUM_LINES(NUM_LINES)) src_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise)
  );

  pic_regs #(.NUM_LINES(NUM_LINES)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .edge_set(rise),
    .ack_fire(ack_fire), .ack_id(best_id),
    .done_fire(done_valid), .done_id(done_id),
    .ena_q(ena_q), .pend_q(pend_q), .act_q(act_q), .prio_q(prio_q), .grp_q(grp_q)
  );

  pic_arb #(.NUM_LINES(NUM_LINES)) arb_i (
    .cand(pend_q & ena_q), .prio(prio_q),
    .found(found), .best_id(best_id), .best_prio(best_prio)
  );

  pic_run #(.NUM_LINES(NUM_LINES)) run_i (
    .act(act_q), .prio(prio_q), .grp(grp_q),
    .idle(cur_idle), .level(cur_level)
  );

  assign best_pre  = preempt_of(best_prio, grp_q);
  assign irq_valid = found && (cur_idle || (best_pre < cur_level));
  assign irq_id    = best_id;
  assign ack_fire  = irq_valid && irq_ready;
endmodule

// File: rtl/pic_chk.sv
`timescale 1ns/1ps
module pic_chk import pic_pkg::*; #(
  parameter  int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             reg_we,
  input logic [ADDR_W-1:0]                reg_addr,
  input logic [DATA_W-1:0]                reg_wdata,
  input logic                             irq_valid,
  input logic [IDX_W-1:0]                 irq_id,
  input logic                             irq_ready,
  input logic                             done_valid,
  input logic [IDX_W-1:0]                 done_id,
  input logic                             cur_idle,
  input logic [PRIO_W-1:0]                cur_level,
  input logic [NUM_LINES-1:0]             ena_q,
  input logic [NUM_LINES-1:0]             pend_q,
  input logic [NUM_LINES-1:0]             act_q,
  input logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q,
  input grp_t                             grp_q
);
  // R8
  sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (ena_q[irq_id] && pend_q[irq_id]));

  // R9
  preempt_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !cur_idle) |-> (preempt_of(prio_q[irq_id], grp_q) < cur_level));

  // R9
  no_self_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !act_q[irq_id]);

  // R10
  ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> act_q[$past(irq_id)]);

  // R10
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !(irq_valid && irq_ready && (irq_id == done_id))) |=> !act_q[$past(done_id)]);

  // R6
  active_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == A_ACTIVE) && !(irq_valid && irq_ready) && !done_valid) |=> $stable(act_q));

  // R2
  ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == A_ENA_SET)) |=> (ena_q == ($past(ena_q) | $past(reg_wdata[NUM_LINES-1:0]))));

  // R11
  idle_no_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_idle |-> (act_q == '0));
endmodule

bind prio_irq_ctrl pic_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_valid(irq_valid), .irq_id(irq_id), .irq_ready(irq_ready),
  .done_valid(done_valid), .done_id(done_id), .cur_idle(cur_idle), .cur_level(cur_level),
  .ena_q(ena_q), .pend_q(pend_q), .act_q(act_q), .prio_q(prio_q), .grp_q(grp_q)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic          reg_we = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_valid;
  logic [2:0]    irq_id;
  logic          irq_ready = 1'b0;
  logic          done_valid = 1'b0;
  logic [2:0]    done_id = '0;
  logic          cur_idle;
  logic [3:0]    cur_level;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.NUM_LINES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_id(irq_id),
    .irq_ready(irq_ready), .done_valid(done_valid), .done_id(done_id),
    .cur_idle(cur_idle), .cur_level(cur_level)
  );

  // ---------------- reference model ----------------
  bit [NL-1:0] m_ena = '0, m_pend = '0, m_act = '0, m_prev = '0;
  int          m_prio [NL];
  int          m_grp = 0;

  initial for (int i = 0; i < NL; i++) m_prio[i] = 0;

  function automatic int pre_of(int p, int g);
    int s = (g > 4) ? 4 : g;
    return p >> s;
  endfunction

  task automatic model_outs(output bit v, output int id, output bit idle, output int lvl);
    bit f = 0;
    int bp = 99;
    id = 0; idle = 1; lvl = 15;
    for (int i = 0; i < NL; i++)
      if (m_act[i]) begin
        idle = 0;
        if (pre_of(m_prio[i], m_grp) < lvl) lvl = pre_of(m_prio[i], m_grp);
      end
    for (int i = 0; i < NL; i++)
      if (m_ena[i] && m_pend[i] && (!f || m_prio[i] < bp)) begin
        f = 1; bp = m_prio[i]; id = i;
      end
    v = f && (idle || pre_of(m_prio[id], m_grp) < lvl);
  endtask

  function automatic int model_rd(int a);
    if (a == 0 || a == 1) return int'(m_ena);
    if (a == 2 || a == 3) return int'(m_pend);
    if (a == 4) return int'(m_act);
    if (a == 6) return m_grp;
    if (a >= 16 && a < 16 + NL) return m_prio[a-16];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ena = '0; m_pend = '0; m_act = '0; m_prev = '0; m_grp = 0;
      for (int i = 0; i < NL; i++) m_prio[i] = 0;
    end else begin
      bit v; int id; bit idl; int lv;
      bit [NL-1:0] np, na, wd;
      model_outs(v, id, idl, lv);
      np = m_pend; na = m_act; wd = reg_wdata[NL-1:0];
      if (v && irq_ready) np[id] = 1'b0;
      if (reg_we && reg_addr == 3) np = np & ~wd;
      if (reg_we && reg_addr == 2) np = np | wd;
      if (reg_we && reg_addr == 5 && reg_wdata < NL) np[reg_wdata] = 1'b1;
      for (int i = 0; i < NL; i++) if (irq_in[i] && !m_prev[i]) np[i] = 1'b1;
      if (done_valid) na[done_id] = 1'b0;
      if (v && irq_ready) na[id] = 1'b1;
      if (reg_we && reg_addr == 0) m_ena = m_ena | wd;
      if (reg_we && reg_addr == 1) m_ena = m_ena & ~wd;
      if (reg_we && reg_addr == 6) m_grp = int'(reg_wdata[2:0]);
      if (reg_we && reg_addr >= 16 && reg_addr < 16 + NL) m_prio[reg_addr-16] = int'(reg_wdata[3:0]);
      m_pend = np; m_act = na; m_prev = irq_in;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit v; int id; bit idl; int lv;
    model_outs(v, id, idl, lv);
    chk(irq_valid == v, "R9 irq_valid", int'(irq_valid), int'(v));
    if (v) chk(int'(irq_id) == id, "R8 irq_id", int'(irq_id), id);
    chk(cur_idle == idl, "R11 cur_idle", int'(cur_idle), int'(idl));
    chk(int'(cur_level) == lv, "R11 cur_level", int'(cur_level), lv);
    chk(int'(reg_rdata) == model_rd(int'(reg_addr)), "R1-map read", int'(reg_rdata), model_rd(int'(reg_addr)));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (cmp_en) compare_all();
  endtask

  task automatic wr(int a, int d);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 32'(d);
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic rd_expect(int a, int exp, string tag);
    reg_addr = 5'(a);
    #1;
    chk(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
  endtask

  task automatic accept();
    irq_ready = 1'b1;
    cyc();
    irq_ready = 1'b0;
  endtask

  task automatic complete(int id);
    done_valid = 1'b1; done_id = 3'(id);
    cyc();
    done_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1;

    // R12 reset state
    chk(irq_valid == 1'b0, "R12 valid after reset", int'(irq_valid), 0);
    chk(cur_idle == 1'b1, "R12 idle after reset", int'(cur_idle), 1);
    rd_expect(0, 0, "R12 enables reset");
    rd_expect(2, 0, "R12 pending reset");
    rd_expect(5'h1F, 0, "R12 unmapped read");

    // R1 priorities
    wr(16, 12); wr(17, 8); wr(18, 10); wr(19, 5);
    wr(20, 6);  wr(21, 9); wr(22, 5);  wr(23, 'hF3);
    rd_expect(23, 3, "R1 upper bits dropped");
    rd_expect(17, 8, "R1 readback");
    wr(23, 15);

    // R7 grouping register width
    wr(6, 'hF);
    rd_expect(6, 7, "R7 group 3 bits");
    wr(6, 2);

    // R2 enables
    wr(0, 'hA5);
    rd_expect(1, 'hA5, "R2 set");
    wr(1, 'h21);
    rd_expect(0, 'h84, "R2 clear");
    wr(0, 0);
    rd_expect(0, 'h84, "R2 zero no effect");
    wr(1, 'hFF);

    // R3 pending
    wr(2, 'h0C);
    rd_expect(3, 'h0C, "R3 set");
    wr(3, 'h04);
    rd_expect(2, 'h08, "R3 clear");
    chk(irq_valid == 1'b0, "R9 no enable no offer", int'(irq_valid), 0);
    wr(3, 'hFF);

    // R5 software trigger
    wr(5, 3);
    rd_expect(2, 'h08, "R5 trigger line 3");
    wr(5, 9);
    rd_expect(2, 'h08, "R5 out of range ignored");
    rd_expect(5, 0, "R5 reads zero");
    wr(3, 'hFF);

    // R4 edge input
    irq_in[2] = 1'b1; cyc();
    rd_expect(2, 'h04, "R4 rising edge pends");
    wr(3, 'h04); cyc(); cyc();
    rd_expect(2, 'h00, "R4 held level no repend");
    irq_in[2] = 1'b0; cyc();
    irq_in[2] = 1'b1; cyc();
    rd_expect(2, 'h04, "R4 second edge");
    irq_in = '0;
    wr(3, 'hFF);

    // R8 arbitration, group 2
    wr(0, 'hFF);
    wr(2, 'h26);
    chk(irq_valid && irq_id == 3'd1, "R8 lowest priority wins", int'(irq_id), 1);
    wr(2, 'h48);
    chk(irq_valid && irq_id == 3'd3, "R8 tie lower index", int'(irq_id), 3);
    accept();
    rd_expect(4, 'h08, "R10 accept sets active");
    rd_expect(2, 'h66, "R10 accept clears pending");
    chk(cur_level == 4'd1, "R11 running level", int'(cur_level), 1);
    chk(irq_valid == 1'b0, "R9 equal level no preempt", int'(irq_valid), 0);
    wr(23, 0);
    wr(2, 'h80);
    chk(irq_valid && irq_id == 3'd7, "R9 strict preempt", int'(irq_id), 7);
    accept();
    chk(cur_level == 4'd0, "R11 nested level", int'(cur_level), 0);
    complete(7);
    rd_expect(4, 'h08, "R10 completion clears");
    chk(cur_level == 4'd1, "R11 level restored", int'(cur_level), 1);
    complete(3);
    chk(cur_idle == 1'b1, "R11 idle again", int'(cur_idle), 1);
    chk(irq_valid && irq_id == 3'd6, "R8 next after idle", int'(irq_id), 6);
    wr(3, 'hFF);

    // R10 accept with same-cycle set
    wr(2, 'h10);
    chk(irq_valid && irq_id == 3'd4, "R8 line 4 offered", int'(irq_id), 4);
    irq_ready = 1'b1; reg_we = 1'b1; reg_addr = 5'd2; reg_wdata = 32'h10;
    cyc();
    irq_ready = 1'b0; reg_we = 1'b0;
    rd_expect(2, 'h10, "R10 set wins over accept");
    rd_expect(4, 'h10, "R10 active set");
    complete(4);
    wr(3, 'hFF);

    // R7 one preemption level, R6 read-only active
    wr(6, 7);
    wr(2, 'h10);
    accept();
    wr(2, 'h80);
    chk(irq_valid == 1'b0, "R7 single level no nesting", int'(irq_valid), 0);
    wr(4, 'hFF);
    rd_expect(4, 'h10, "R6 active write ignored");
    complete(4);
    chk(irq_valid && irq_id == 3'd7, "R7 served after completion", int'(irq_id), 7);
    wr(3, 'hFF);
    cyc();

    finish_run();
  end
endmodule